// File: doc/BRIEF.md
# Adaptive bridge non-overlap generator

This block drives the four gate enables of a full bridge: high and low switch of the left leg, and high and low switch of the right leg. A commutation controller names the wanted gate set with a two-bit code and pulses a change strobe. The block first removes every gate of the set that is conducting, holds all four off for a dead interval, and only then enables the new set.

Between the two diagonal pairs, the dead interval adapts to the load. It lasts until the switching node of the leg whose high switch was just released reports that its falling slope is over. It never ends before a programmable minimum, and it never runs past a programmable maximum. Moves into or out of the parked codes (all off, or both low switches on) use only the minimum.

A disable input blanks all four gates in the same cycle and abandons any interval in progress. The node slope flags are produced by an analog comparator outside this block.

Top module: `bridge_deadtime_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, all four gate outputs are low.
- R2: The code on `pair_sel` selects a gate set: 2'b00 none, 2'b01 both low switches (`gate_ll`, `gate_lr`), 2'b10 `gate_hl` with `gate_lr`, 2'b11 `gate_hr` with `gate_ll`. The selected set is driven once the dead interval ends.
- R3: A request sampled at a clock edge drives all gates low from that edge. No gate of the new set rises before all four have been low for `MIN_DEAD` cycles. With no slope wait, the new set appears exactly `MIN_DEAD` cycles after the request edge.
- R4: When moving between code 2'b10 and code 2'b11, the interval also waits for the outgoing node's slope flag to be low: `slope_l` when leaving 2'b10, `slope_r` when leaving 2'b11. The new set appears at the first edge where that flag is low and at least `MIN_DEAD` cycles have passed.
- R5: During such a move, the slope flag of the other node has no effect on the interval length.
- R6: If the watched slope flag stays high, the new set appears `MAX_WAIT` cycles after the request edge.
- R7: A move whose source or destination code is 2'b00 or 2'b01 ignores both slope flags and lasts exactly `MIN_DEAD` cycles.
- R8: A request during a dead interval replaces the target and restarts the count from zero, with the gates kept low. The slope flag watched remains that of the set conducting before the first request.
- R9: `force_off` high drives all four gates low in the same cycle, abandons any interval, and causes requests to be ignored. After it falls, the gates stay low until a new request. That request uses only the minimum time.
- R10: A request for the code already being driven, made outside a dead interval, is ignored and the gates do not change.
- R11: `gate_hl` and `gate_ll` are never high together, and `gate_hr` and `gate_lr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_sel | input | 2 | Requested gate set code |
| pair_req | input | 1 | One-cycle change strobe |
| force_off | input | 1 | Blank all gates and abandon any interval |
| slope_l | input | 1 | Left node falling slope in progress |
| slope_r | input | 1 | Right node falling slope in progress |
| gate_hl | output | 1 | Left high switch enable |
| gate_ll | output | 1 | Left low switch enable |
| gate_hr | output | 1 | Right high switch enable |
| gate_lr | output | 1 | Right low switch enable |

## Verification
The assertions assume that the slope flags and the strobe are already synchronous to the clock and that `MAX_WAIT` exceeds `MIN_DEAD`. Under those assumptions they treat any overlap of a leg, or any set-to-set change without an all-off gap of the minimum length, as a design fault. The stimulus changes every input only on the falling clock edge. It raises a slope flag before the request that should observe it and lowers it at a counted cycle after the request, so every expected turn-on cycle is known in advance. Disable is asserted both while a set is conducting and in the middle of a slope wait.

// File: rtl/bridge_deadtime_gen.sv
module bridge_deadtime_gen #(
  parameter int MIN_DEAD = 225,
  parameter int MAX_WAIT = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pair_sel,
  input  logic       pair_req,
  input  logic       force_off,
  input  logic       slope_l,
  input  logic       slope_r,
  output logic       gate_hl,
  output logic       gate_ll,
  output logic       gate_hr,
  output logic       gate_lr
);
  localparam int CW = $clog2(MAX_WAIT + 1);

  function automatic logic [3:0] decode(input logic [1:0] code);
    case (code)
      2'b01:   decode = 4'b0101;
      2'b10:   decode = 4'b1001;
      2'b11:   decode = 4'b0110;
      default: decode = 4'b0000;
    endcase
  endfunction

  logic [1:0]    cur_q, tgt_q, src_q;
  logic          dead_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    gate_q;

  wire alt_move  = src_q[1] & tgt_q[1];
  wire watched   = src_q[0] ? slope_r : slope_l;
  wire min_done  = cnt_q >= CW'(MIN_DEAD - 1);
  wire timed_out = cnt_q >= CW'(MAX_WAIT - 1);
  wire settle    = min_done & (~alt_move | ~watched | timed_out);
  wire accept    = pair_req & (dead_q | (pair_sel != cur_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= 2'b00;
      tgt_q  <= 2'b00;
      src_q  <= 2'b00;
      dead_q <= 1'b0;
      cnt_q  <= '0;
      gate_q <= 4'b0000;
    end else if (force_off) begin
      cur_q  <= 2'b00;
      src_q  <= 2'b00;
      dead_q <= 1'b0;
      cnt_q  <= '0;
      gate_q <= 4'b0000;
    end else if (accept) begin
      dead_q <= 1'b1;
      tgt_q  <= pair_sel;
      cnt_q  <= '0;
      gate_q <= 4'b0000;
      if (!dead_q) src_q <= cur_q;
    end else if (dead_q) begin
      if (settle) begin
        dead_q <= 1'b0;
        cur_q  <= tgt_q;
        gate_q <= decode(tgt_q);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign gate_hl = gate_q[3] & ~force_off;
  assign gate_ll = gate_q[2] & ~force_off;
  assign gate_hr = gate_q[1] & ~force_off;
  assign gate_lr = gate_q[0] & ~force_off;

  logic [CW-1:0] off_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                        off_run <= '0;
    else if (gate_q != 4'b0000)        off_run <= '0;
    else if (off_run < CW'(MIN_DEAD))  off_run <= off_run + 1'b1;
  end

  AST_LEFT_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hl && gate_ll)); // R11
  AST_RIGHT_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hr && gate_lr)); // R11
  AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != 4'b0000 && $past(gate_q) != 4'b0000) |-> gate_q == $past(gate_q)); // R3
  AST_MIN_OFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != 4'b0000 && $past(gate_q) == 4'b0000) |-> off_run >= CW'(MIN_DEAD)); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> gate_q == 4'b0000); // R9
  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |-> cnt_q < CW'(MAX_WAIT)); // R6
endmodule

// File: tb/bridge_deadtime_gen_tb_top.sv
module bridge_deadtime_gen_tb_top;
  localparam int MIN = 8;
  localparam int MAX = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic req = 1'b0, dis = 1'b0, sl = 1'b0, sr = 1'b0;
  logic hl, ll, hr, lr;
  wire [3:0] g = {hl, ll, hr, lr};

  always #2 clk = ~clk;

  bridge_deadtime_gen #(.MIN_DEAD(MIN), .MAX_WAIT(MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .pair_sel(sel), .pair_req(req), .force_off(dis),
    .slope_l(sl), .slope_r(sr), .gate_hl(hl), .gate_ll(ll), .gate_hr(hr), .gate_lr(lr));

  typedef struct packed { logic [3:0] g; int c; } item_t;
  item_t q[$];
  string tq[$];
  int cyc = 0, checks = 0, fails = 0;
  logic [3:0] exp_g = 4'b0, last_g = 4'b0;
  bit mon_on = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] dec(input logic [1:0] t);
    case (t)
      2'b01: dec = 4'b0101;
      2'b10: dec = 4'b1001;
      2'b11: dec = 4'b0110;
      default: dec = 4'b0000;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] v, input int c, input string tag);
    item_t it;
    it.g = v; it.c = c;
    q.push_back(it);
    tq.push_back(tag);
  endtask

  always begin
    @(posedge clk); #1;
    if (mon_on && g !== last_g) begin
      if (q.size() == 0) check(0, "R3 unexpected gate change", int'(g), int'(last_g));
      else begin
        item_t it;
        string t;
        it = q.pop_front();
        t = tq.pop_front();
        check(g == it.g, {t, " gates"}, int'(g), int'(it.g));
        check(cyc == it.c, {t, " cycle"}, cyc, it.c);
      end
    end
    last_g = g;
  end

  task automatic request(input logic [1:0] t, input int w, input string tag);
    int n;
    @(negedge clk);
    sel = t; req = 1'b1; n = cyc;
    if (exp_g != 4'b0) push(4'b0, n + 1, tag);
    if (w >= 0 && dec(t) != 4'b0) push(dec(t), n + 1 + w, tag);
    exp_g = (w >= 0) ? dec(t) : 4'b0;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic settle(input string tag);
    repeat (MAX + 4) @(negedge clk);
    check(!(g[3] & g[2]) && !(g[1] & g[0]), {tag, " R11 leg exclusion"}, int'(g), int'(exp_g));
    check(g == exp_g, {tag, " settled"}, int'(g), int'(exp_g));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(g == 4'b0, "R1 reset gates", int'(g), 0);
    rst_n = 1'b1;
    mon_on = 1;
    repeat (3) @(negedge clk);
    check(g == 4'b0, "R1 after release", int'(g), 0);

    request(2'b01, MIN, "R2 R7 off to lows"); settle("R2");
    sl = 1'b1;
    request(2'b10, MIN, "R7 lows to A slope ignored"); settle("R7");
    request(2'b11, 20, "R4 A to B left slope");
    repeat (19) @(negedge clk); sl = 1'b0; settle("R4");
    sl = 1'b1;
    request(2'b10, MIN, "R5 B to A left flag ignored"); settle("R5");
    sl = 1'b0; sr = 1'b1;
    request(2'b11, MIN, "R5 A to B right flag ignored"); settle("R5");
    request(2'b10, MAX, "R6 timeout on stuck right flag"); settle("R6");
    sr = 1'b0; sl = 1'b1;
    request(2'b11, MIN, "R4 early drop uses minimum");
    repeat (2) @(negedge clk); sl = 1'b0; settle("R4");

    @(negedge clk); sel = 2'b11; req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (10) @(negedge clk);
    check(g == dec(2'b11), "R10 same code ignored", int'(g), int'(dec(2'b11)));

    sr = 1'b1;
    request(2'b10, -1, "R8 first request");
    repeat (3) @(negedge clk); sr = 1'b0;
    request(2'b01, MIN, "R8 restart"); settle("R8");

    begin
      int n;
      @(negedge clk); dis = 1'b1; n = cyc;
      push(4'b0, n + 1, "R9 blank while on");
      exp_g = 4'b0;
    end
    request(2'b10, -1, "R9 ignored");
    repeat (5) @(negedge clk);
    check(g == 4'b0, "R9 request ignored while disabled", int'(g), 0);
    dis = 1'b0;
    repeat (10) @(negedge clk);
    check(g == 4'b0, "R9 stays off after release", int'(g), 0);
    sl = 1'b1;
    request(2'b10, MIN, "R9 after release minimum only"); settle("R9");

    request(2'b11, -1, "R9 mid interval");
    repeat (3) @(negedge clk); dis = 1'b1;
    repeat (MAX + 5) @(negedge clk);
    dis = 1'b0; sl = 1'b0;
    repeat (5) @(negedge clk);
    check(g == 4'b0, "R9 interval abandoned", int'(g), 0);

    request(2'b01, MIN, "R2 lows again"); settle("R2");
    request(2'b00, MIN, "R2 code none"); settle("R2");

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R3 pending expected events", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      check(0, "watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule